// File: doc/BRIEF.md
# Instruction Cache Line-Fill Read Master

This block sits between an instruction cache controller and a read-only memory bus that follows AXI4 read channel rules (AR and R). When the cache misses, it receives a line request. It issues one incrementing burst that covers the whole line. It then hands the returned words back in order on a plain fill interface, with each word's address, a last-word marker and an error flag on the last word. Requests that should not use the cache are steered to a bypass output instead. That happens when caching is switched off at run time and the always-use-cache option is not set.

The data-path width is a parameter. At 32 bits a line of 4, 8 or 16 words arrives as a multi-beat burst, and several line fills may be in flight. With stream prefetch enabled, each demand fill is followed by requests for the next two lines, unless another demand arrives first. At 128, 256 or 512 bits a whole line arrives in one beat, only one read may be outstanding, and prefetch is off. A flush input cancels prefetches that have not yet been issued. It also hides the data of prefetches still in flight, while their beats are still drained from the bus.

Top module: `ic_fill_master`

## Requirements
- R1: In 32-bit mode every read request has burst type INCR (code 2'b01), size code 2 (4 bytes), length field equal to the line word count minus one, and an address with all line-offset bits cleared. A request address inside a line is rounded down to the line start.
- R2: In wide mode (data width above 32 bits) every read request has length field 0 and size code log2(data width / 8), and the line is as many bytes as one beat. At most one read is outstanding.
- R3: In 32-bit mode without prefetch at most 2 reads are outstanding, and with prefetch at most 5. Once the limit is reached, `req_ready` is low and no further address is issued until a fill completes.
- R4: With prefetch enabled, a demand request for line L is followed, when no other demand intervenes, by requests for lines L+1 and L+2 in that order. A new demand takes priority over pending prefetches and restarts them from its own line.
- R5: Each accepted data beat of a live fill appears on the fill outputs in the same cycle. `fill_data` equals the bus data, `fill_addr` equals the line start plus 4 times the beat index, and `fill_last` is high on the beat marked last. Fills come out in issue order.
- R6: `fill_err` is high on the last beat of a fill when any beat of that fill had a response code other than OKAY (2'b00). It starts clear for the next fill.
- R7: A one-cycle `flush` drops all prefetches not yet presented on the address channel. Beats belonging to prefetches that were already issued are accepted from the bus but produce no `fill_valid`. Demand fills are unaffected.
- R8: When `cache_en` is 0 and the always-use-cache parameter is 0, a request appears at once on `byp_valid` and `byp_addr`, `req_ready` is high, and no read is issued. With the parameter set to 1, requests always go to the bus.
- R9: Once `ar_valid` is high it stays high with an unchanged address until `ar_ready` accepts it, even across a flush.
- R10: During reset `ar_valid` and `fill_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Run-time cache enable |
| flush | input | 1 | Cancel pending and in-flight prefetches |
| req_valid | input | 1 | Line request valid |
| req_addr | input | ADDR_W | Requested byte address |
| req_ready | output | 1 | Request accepted this cycle |
| byp_valid | output | 1 | Request routed to bypass path |
| byp_addr | output | ADDR_W | Bypass address |
| ar_valid | output | 1 | Read address valid |
| ar_addr | output | ADDR_W | Line-aligned read address |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type (INCR) |
| ar_ready | input | 1 | Read address accepted |
| r_valid | input | 1 | Read data valid |
| r_data | input | DATA_W | Read data |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Last beat of burst |
| r_ready | output | 1 | Always ready for read data |
| fill_valid | output | 1 | Fill word valid |
| fill_addr | output | ADDR_W | Address of fill word |
| fill_data | output | DATA_W | Fill word |
| fill_last | output | 1 | Last word of line |
| fill_err | output | 1 | Line had an error response |

## Verification
The hardest state to reach is a full tracker in prefetch mode with a mix of demand and prefetch entries outstanding, and then a flush. The stimulus gets there by spacing two demand requests far enough apart that both prefetch pairs issue, while no read data is returned. It then frees one slot so the blocked prefetch goes out, flushes, and drains all five bursts in order, expecting fill words only for the demand line. A second scenario holds the address channel stalled while a flush cancels the pending prefetches behind a waiting request. The scenario then confirms that only that request is issued.

// File: rtl/ic_fill_master.sv
module ic_fill_master #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int LINE_WORDS   = 8,
  parameter bit PREFETCH     = 1'b1,
  parameter bit ALWAYS_CACHE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              byp_valid,
  output logic [ADDR_W-1:0] byp_addr,
  output logic              ar_valid,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              ar_ready,
  input  logic              r_valid,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              r_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_last,
  output logic              fill_err
);
  localparam bit WIDE    = DATA_W > 32;
  localparam int LW      = WIDE ? DATA_W / 32 : LINE_WORDS;
  localparam int OFF     = $clog2(LW * 4);
  localparam int BEATS   = WIDE ? 1 : LW;
  localparam bit PF_EN   = PREFETCH && !WIDE;
  localparam int MAX_OUT = WIDE ? 1 : (PF_EN ? 5 : 2);
  localparam int TRK_D   = 1 << $clog2(MAX_OUT);
  localparam int PW      = TRK_D > 1 ? $clog2(TRK_D) : 1;
  localparam int SLOTS   = 1 << PW;
  localparam int BW      = BEATS > 1 ? $clog2(BEATS) : 1;
  localparam int LA_W    = ADDR_W - OFF;
  localparam logic [PW:0]   OCC_MAX  = (PW + 1)'(MAX_OUT);
  localparam logic [PW-1:0] LAST_IDX = PW'(TRK_D - 1);

  logic [LA_W-1:0]  ar_line, pf_line;
  logic             ar_pf, ar_sq;
  logic [1:0]       pf_cnt;
  logic [LA_W-1:0]  t_line [SLOTS];
  logic [SLOTS-1:0] t_pf, t_sq;
  logic [PW-1:0]    wp, rp;
  logic [PW:0]      occ;
  logic [BW-1:0]    beat;
  logic             err_acc;

  wire use_cache = ALWAYS_CACHE || cache_en;
  wire can_load  = !ar_valid && (occ < OCC_MAX);
  wire dem_load  = req_valid && use_cache && can_load;
  wire pf_load   = PF_EN && !dem_load && can_load && (pf_cnt != 2'd0) && !flush;
  wire push      = ar_valid && ar_ready;
  wire live_beat = r_valid && (occ != '0);
  wire pop       = live_beat && r_last;
  wire bad       = r_resp != 2'b00;

  assign req_ready = use_cache ? can_load : 1'b1;
  assign byp_valid = req_valid && !use_cache;
  assign byp_addr  = req_addr;

  assign ar_addr  = {ar_line, {OFF{1'b0}}};
  assign ar_len   = 8'(BEATS - 1);
  assign ar_size  = WIDE ? 3'($clog2(DATA_W / 8)) : 3'd2;
  assign ar_burst = 2'b01;
  assign r_ready  = 1'b1;

  assign fill_valid = live_beat && !t_sq[rp];
  assign fill_addr  = {t_line[rp], {OFF{1'b0}}} + {{(ADDR_W-BW-2){1'b0}}, beat, 2'b00};
  assign fill_data  = r_data;
  assign fill_last  = fill_valid && r_last;
  assign fill_err   = fill_last && (err_acc || bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_valid <= 1'b0;
      ar_line  <= '0;
      ar_pf    <= 1'b0;
      ar_sq    <= 1'b0;
    end else begin
      if (dem_load || pf_load) begin
        ar_valid <= 1'b1;
        ar_line  <= dem_load ? req_addr[ADDR_W-1:OFF] : pf_line;
        ar_pf    <= pf_load;
        ar_sq    <= 1'b0;
      end else begin
        if (push) ar_valid <= 1'b0;
        if (flush && ar_valid && ar_pf) ar_sq <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_cnt  <= 2'd0;
      pf_line <= '0;
    end else begin
      if (dem_load) begin
        pf_line <= req_addr[ADDR_W-1:OFF] + 1'b1;
        pf_cnt  <= PF_EN ? 2'd2 : 2'd0;
      end else if (pf_load) begin
        pf_line <= pf_line + 1'b1;
        pf_cnt  <= pf_cnt - 1'b1;
      end
      if (flush) pf_cnt <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) t_line[wp] <= ar_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_pf    <= '0;
      t_sq    <= '0;
      wp      <= '0;
      rp      <= '0;
      occ     <= '0;
      beat    <= '0;
      err_acc <= 1'b0;
    end else begin
      if (flush) begin
        for (int i = 0; i < SLOTS; i++)
          if (t_pf[i]) t_sq[i] <= 1'b1;
      end
      if (push) begin
        t_pf[wp] <= ar_pf;
        t_sq[wp] <= ar_sq || (flush && ar_pf);
        wp       <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      occ <= occ + (PW + 1)'(push) - (PW + 1)'(pop);
      if (live_beat) begin
        beat    <= r_last ? '0 : beat + 1'b1;
        err_acc <= r_last ? 1'b0 : (err_acc || bad);
      end
    end
  end
endmodule

module ic_fill_master_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF     = 5,
  parameter int BEATS   = 8,
  parameter int MAX_OUT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic [1:0]        ar_burst,
  input logic              r_valid,
  input logic              r_last,
  input logic              fill_valid
);
  logic [7:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 8'd0;
    else inflight <= inflight + 8'(ar_valid && ar_ready)
                              - 8'(r_valid && r_last && inflight != 8'd0);
  end

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr)); // R9
  AST_AR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_addr[OFF-1:0] == '0 && ar_len == 8'(BEATS - 1) && ar_burst == 2'b01); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(MAX_OUT)); // R3
  AST_FILL_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> inflight != 8'd0); // R5
endmodule

bind ic_fill_master ic_fill_master_chk #(
  .ADDR_W(ADDR_W), .OFF(OFF), .BEATS(BEATS), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .ar_addr(ar_addr), .ar_len(ar_len), .ar_burst(ar_burst),
  .r_valid(r_valid), .r_last(r_last), .fill_valid(fill_valid)
);

// File: tb/sim_ic_fill_master.sv
module sim_ic_fill_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;

  logic cache_en = 1'b0, flush = 1'b0, req_valid = 1'b0, ar_ready = 1'b1;
  logic [31:0] req_addr = '0, r_data = '0;
  logic r_valid = 1'b0, r_last = 1'b0;
  logic [1:0] r_resp = 2'b00;
  wire req_ready, byp_valid, ar_valid, r_ready, fill_valid, fill_last, fill_err;
  wire [31:0] byp_addr, ar_addr, fill_addr, fill_data;
  wire [7:0] ar_len; wire [2:0] ar_size; wire [1:0] ar_burst;

  ic_fill_master #(.DATA_W(32), .LINE_WORDS(8), .PREFETCH(1'b1), .ALWAYS_CACHE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .byp_valid(byp_valid), .byp_addr(byp_addr),
    .ar_valid(ar_valid), .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
    .ar_burst(ar_burst), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_data(r_data), .r_resp(r_resp), .r_last(r_last), .r_ready(r_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_last(fill_last), .fill_err(fill_err));

  logic w_req_valid = 1'b0;
  wire w_req_ready, w_byp_valid, w_ar_valid, w_r_ready, w_fill_valid, w_fill_last, w_fill_err;
  wire [31:0] w_byp_addr, w_ar_addr, w_fill_addr;
  wire [127:0] w_fill_data;
  wire [7:0] w_ar_len; wire [2:0] w_ar_size; wire [1:0] w_ar_burst;

  ic_fill_master #(.DATA_W(128), .PREFETCH(1'b1), .ALWAYS_CACHE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cache_en(1'b0), .flush(1'b0),
    .req_valid(w_req_valid), .req_addr(32'h0000_1234), .req_ready(w_req_ready),
    .byp_valid(w_byp_valid), .byp_addr(w_byp_addr),
    .ar_valid(w_ar_valid), .ar_addr(w_ar_addr), .ar_len(w_ar_len), .ar_size(w_ar_size),
    .ar_burst(w_ar_burst), .ar_ready(1'b1),
    .r_valid(1'b0), .r_data(128'h0), .r_resp(2'b00), .r_last(1'b0), .r_ready(w_r_ready),
    .fill_valid(w_fill_valid), .fill_addr(w_fill_addr), .fill_data(w_fill_data),
    .fill_last(w_fill_last), .fill_err(w_fill_err));

  logic n_req_valid = 1'b0;
  wire n_req_ready, n_byp_valid, n_ar_valid, n_r_ready, n_fill_valid, n_fill_last, n_fill_err;
  wire [31:0] n_byp_addr, n_ar_addr, n_fill_addr, n_fill_data;
  wire [7:0] n_ar_len; wire [2:0] n_ar_size; wire [1:0] n_ar_burst;

  ic_fill_master #(.DATA_W(32), .LINE_WORDS(4), .PREFETCH(1'b0), .ALWAYS_CACHE(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .cache_en(1'b1), .flush(1'b0),
    .req_valid(n_req_valid), .req_addr(32'h0000_0100), .req_ready(n_req_ready),
    .byp_valid(n_byp_valid), .byp_addr(n_byp_addr),
    .ar_valid(n_ar_valid), .ar_addr(n_ar_addr), .ar_len(n_ar_len), .ar_size(n_ar_size),
    .ar_burst(n_ar_burst), .ar_ready(1'b1),
    .r_valid(1'b0), .r_data(32'h0), .r_resp(2'b00), .r_last(1'b0), .r_ready(n_r_ready),
    .fill_valid(n_fill_valid), .fill_addr(n_fill_addr), .fill_data(n_fill_data),
    .fill_last(n_fill_last), .fill_err(n_fill_err));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [31:0] a; logic [31:0] d; bit last; bit err; } item_t;
  item_t exp_q[$];
  logic [31:0] ar_q[$];
  int ar_cnt = 0, w_cnt = 0, n_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && ar_valid && ar_ready) begin
      ar_q.push_back(ar_addr);
      ar_cnt++;
      check(ar_len == 8'd7 && ar_burst == 2'b01 && ar_size == 3'd2, "R1", "len/burst/size",
            {ar_len, ar_burst, ar_size}, {8'd7, 2'b01, 3'd2});
    end
    if (rst_n && w_ar_valid) begin
      w_cnt++;
      check(w_ar_addr == 32'h1230 && w_ar_len == 8'd0 && w_ar_size == 3'd4, "R2", "wide request",
            {w_ar_addr, w_ar_len, w_ar_size}, {32'h1230, 8'd0, 3'd4});
    end
    if (rst_n && n_ar_valid) begin
      n_cnt++;
      check(n_ar_addr == 32'h100 && n_ar_len == 8'd3, "R1", "4-word request",
            {n_ar_addr, n_ar_len}, {32'h100, 8'd3});
    end
  end

  always @(negedge clk) begin
    if (rst_n && fill_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R7", "unexpected fill word", fill_addr, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check(fill_addr == e.a, "R5", "fill_addr", fill_addr, e.a);
        check(fill_data == e.d, "R5", "fill_data", fill_data, e.d);
        check(fill_last == e.last, "R5", "fill_last", fill_last, e.last);
        check(fill_err == e.err, "R6", "fill_err", fill_err, e.err);
      end
    end
  end

  task automatic do_req(input logic [31:0] a);
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = a;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic serve(input bit fills, input int err_beat);
    logic [31:0] a;
    item_t e;
    a = ar_q.pop_front();
    for (int b = 0; b < 8; b++) begin
      @(posedge clk); #2;
      r_valid = 1'b1;
      r_data  = {a[15:0], 8'h5a, 8'(b)};
      r_resp  = (b == err_beat) ? 2'b10 : 2'b00;
      r_last  = (b == 7);
      if (fills) begin
        e.a = a + 32'(4 * b); e.d = r_data; e.last = (b == 7);
        e.err = (b == 7) && (err_beat >= 0);
        exp_q.push_back(e);
      end
    end
    @(posedge clk); #2;
    r_valid = 1'b0; r_last = 1'b0; r_resp = 2'b00;
  endtask

  task automatic pulse_flush();
    @(posedge clk); #2; flush = 1'b1;
    @(posedge clk); #2; flush = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!ar_valid && !fill_valid && req_ready, "R10", "reset outputs",
          {ar_valid, fill_valid, req_ready}, 3'b001);
    @(posedge clk); #2; rst_n = 1'b1; w_req_valid = 1'b1; n_req_valid = 1'b1;

    @(posedge clk); #2; req_valid = 1'b1; req_addr = 32'h0000_7004;
    @(negedge clk);
    check(byp_valid && req_ready, "R8", "bypass valid/ready", {byp_valid, req_ready}, 2'b11);
    check(byp_addr == 32'h7004, "R8", "bypass address", byp_addr, 32'h7004);
    @(posedge clk); #2; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(ar_cnt == 0, "R8", "no read on bypass", ar_cnt, 0);
    check(!w_byp_valid, "R8", "always-cache never bypasses", w_byp_valid, 0);

    cache_en = 1'b1;
    do_req(32'h1000);
    repeat (8) @(negedge clk);
    check(ar_cnt == 3, "R4", "demand plus two prefetches", ar_cnt, 3);
    check(ar_q[0] == 32'h1000 && ar_q[1] == 32'h1020 && ar_q[2] == 32'h1040, "R4",
          "prefetch order", {ar_q[1], ar_q[2]}, {32'h1020, 32'h1040});
    serve(1'b1, -1);
    serve(1'b1, 3);
    serve(1'b1, -1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6", "all fills seen", exp_q.size(), 0);

    do_req(32'h2014);
    repeat (8) @(negedge clk);
    check(ar_q[0] == 32'h2000, "R1", "aligned line address", ar_q[0], 32'h2000);
    serve(1'b1, 7); serve(1'b1, -1); serve(1'b1, -1);

    do_req(32'h3000);
    repeat (8) @(negedge clk);
    do_req(32'h4000);
    repeat (10) @(negedge clk);
    check(ar_cnt == 11, "R3", "five outstanding", ar_cnt, 11);
    check(!req_ready, "R3", "ready low at limit", req_ready, 0);
    serve(1'b1, -1);
    repeat (6) @(negedge clk);
    check(ar_cnt == 12 && ar_q[$] == 32'h4040, "R3", "slot freed issues next",
          ar_q[$], 32'h4040);

    pulse_flush();
    serve(1'b0, -1); serve(1'b0, -1); serve(1'b1, -1); serve(1'b0, -1); serve(1'b0, -1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", "demand fill survives flush", exp_q.size(), 0);

    @(posedge clk); #2; ar_ready = 1'b0;
    do_req(32'h6000);
    repeat (2) @(negedge clk);
    check(ar_valid && ar_addr == 32'h6000, "R9", "held request", ar_addr, 32'h6000);
    pulse_flush();
    repeat (3) @(negedge clk);
    check(ar_valid && ar_addr == 32'h6000, "R9", "held across flush", ar_addr, 32'h6000);
    @(posedge clk); #2; ar_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(ar_cnt == 13, "R7", "pending prefetches dropped", ar_cnt, 13);
    serve(1'b1, -1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

    check(w_cnt == 1, "R2", "single outstanding in wide mode", w_cnt, 1);
    check(n_cnt == 2, "R3", "two outstanding without prefetch", n_cnt, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule